// File: doc/BRIEF.md
# Configuration load sequencer

This block takes the place of a processor routine that configures a downstream programmable device over a byte-wide parallel port. It owns the device's active-low program line and reads back the device's init and done status lines. A load clears the device with a two-phase program/init handshake and then passes the configuration bytes from a valid/ready stream to the device's data port. It waits for the device to report done and then gives a result code. A separate command runs the clearing handshake alone.

All waits are polled. A prescaler turns the clock into a microsecond tick, and a poll timer samples the awaited status line every `POLL_TICKS` ticks. A wait gives up after `MAX_POLLS` samples. In an automatic load, the block skips the work when the device is already configured with the same image. It also skips when there was no power-on reset. An odd byte count is padded to even. After a failed done wait, the init level tells a size problem from a checksum problem.

Top module: `cfg_load_seq`

## Requirements
- R1: While rst_ni is low and right after it: prog_no is 1, and s_ready_o, dev_we_o, load_mode_o, busy_o and fin_o are 0.
- R2: A command first drives prog_no low. The block samples init_i only at poll instants, the first one POLL_TICKS*CLK_PER_TICK cycles after entry. The program line rises at the first poll that sees init_i low. prog_no is never low while load_mode_o is high.
- R3: Phase two holds prog_no high and polls until init_i reads high.
- R4: When either phase sees MAX_POLLS polls without the awaited level, the command ends with err_o = 1. No byte is requested after this. A phase-one timeout gives fin_o exactly MAX_POLLS*POLL_TICKS*CLK_PER_TICK+1 cycles after the start pulse.
- R5: s_ready_o is high only while load_mode_o is high. Each accepted byte shows on dev_data_o with a one-cycle dev_we_o, in stream order, while load_mode_o is still high.
- R6: When len_i is odd, exactly one extra byte of value 0x00 is written after the last stream byte. The write count is then len_i+1.
- R7: After the last write, load_mode_o drops and the block polls done_i. If done_i is high at a poll, the result is err_o = 0.
- R8: If done_i stays low for MAX_POLLS polls, err_o is 2 when init_i is high at the last poll and 3 when it is low.
- R9: A start with auto_i=1, por_i=0, done_i=1 and new_id_i equal to cur_id_i gives fin_o with err_o = 4 in the next cycle. prog_no stays high and nothing is written. If any one of these conditions is false, the block runs a full load.
- R10: reset_only_i runs only the two phases and ends with err_o = 0, or 1 on timeout, without entering load mode.
- R11: fin_o is a one-cycle pulse, and err_o is valid with it. busy_o is high from the cycle after an accepted command until fin_o. start_i and reset_only_i are ignored while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| start_i | input | 1 | load command pulse |
| reset_only_i | input | 1 | handshake-only command pulse |
| auto_i | input | 1 | automatic load, allows the up-to-date skip |
| por_i | input | 1 | a power-on reset happened |
| len_i | input | LEN_W | image byte count, sampled with start_i |
| new_id_i | input | ID_W | ID of the image to load |
| cur_id_i | input | ID_W | ID read back from the device |
| s_data_i | input | DATA_W | stream byte |
| s_valid_i | input | 1 | stream byte valid |
| s_ready_o | output | 1 | stream byte accepted |
| prog_no | output | 1 | device program line, active low |
| init_i | input | 1 | device init status |
| done_i | input | 1 | device done status |
| load_mode_o | output | 1 | device port in load mode |
| dev_data_o | output | DATA_W | byte to the device |
| dev_we_o | output | 1 | device write strobe |
| busy_o | output | 1 | command in progress |
| fin_o | output | 1 | command finished pulse |
| err_o | output | 3 | result code, valid with fin_o |

## Verification
The assertions assume that commands come only as single-cycle pulses. They also assume that the stream holds no more bytes than len_i announced, since the skip property ties a start in idle to the very next cycle. The bench drives start_i and reset_only_i for one cycle and waits for fin_o before it sends another command, except in the one case that tests the ignore rule. Its source never offers more bytes than the announced count. A device model returns init_i as the program line delayed by two cycles, so each phase ends at its first poll. Forced init levels reach the timeout paths.

// File: rtl/cfg_load_pkg.sv
`timescale 1ns/1ps
package cfg_load_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PROG_LO, ST_PROG_HI, ST_STREAM, ST_WAIT_DONE, ST_FIN
  } seq_state_e;

  typedef enum logic [2:0] {
    ERR_OK          = 3'd0,
    ERR_RST_TIMEOUT = 3'd1,
    ERR_BAD_SIZE    = 3'd2,
    ERR_BAD_CRC     = 3'd3,
    ERR_SKIPPED     = 3'd4
  } load_err_e;
endpackage

// File: rtl/cfg_us_tick.sv
`timescale 1ns/1ps
module cfg_us_tick #(
  parameter int CLK_PER_TICK = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int CW = $clog2(CLK_PER_TICK + 1);
  localparam logic [CW-1:0] LAST = CW'(CLK_PER_TICK - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/cfg_poll_timer.sv
`timescale 1ns/1ps
module cfg_poll_timer #(
  parameter int POLL_TICKS = 100,
  parameter int MAX_POLLS  = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  output logic poll_o,
  output logic last_o
);
  localparam int TW = $clog2(POLL_TICKS + 1);
  localparam int PW = $clog2(MAX_POLLS + 1);
  localparam logic [TW-1:0] T_LAST = TW'(POLL_TICKS - 1);
  localparam logic [PW-1:0] P_LAST = PW'(MAX_POLLS - 1);

  logic [TW-1:0] tick_q;
  logic [PW-1:0] poll_q;

  assign poll_o = tick_i && (tick_q == T_LAST);
  assign last_o = poll_o && (poll_q == P_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= '0;
      poll_q <= '0;
    end else if (clr_i) begin
      tick_q <= '0;
      poll_q <= '0;
    end else if (tick_i) begin
      tick_q <= poll_o ? '0 : tick_q + TW'(1);
      if (poll_o && !last_o) poll_q <= poll_q + PW'(1);
    end
  end
endmodule

// File: rtl/cfg_byte_pump.sv
`timescale 1ns/1ps
module cfg_byte_pump #(
  parameter int                LEN_W    = 24,
  parameter int                DATA_W   = 8,
  parameter logic [DATA_W-1:0] PAD_BYTE = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              en_i,
  input  logic [DATA_W-1:0] s_data_i,
  input  logic              s_valid_i,
  output logic              s_ready_o,
  output logic [DATA_W-1:0] dev_data_o,
  output logic              dev_we_o,
  output logic              empty_o
);
  logic [LEN_W-1:0]  rem_q;
  logic              pad_q;
  logic              we_q;
  logic [DATA_W-1:0] data_q;
  logic              take;
  logic              pad_go;

  assign s_ready_o  = en_i && (rem_q != '0);
  assign take       = s_ready_o && s_valid_i;
  assign pad_go     = en_i && (rem_q == '0) && pad_q;
  // empty only once the final strobe has left the output register
  assign empty_o    = (rem_q == '0) && !pad_q && !we_q;
  assign dev_data_o = data_q;
  assign dev_we_o   = we_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      pad_q <= 1'b0;
    end else if (ld_i) begin
      rem_q <= len_i;
      pad_q <= len_i[0];
    end else begin
      if (take)   rem_q <= rem_q - LEN_W'(1);
      if (pad_go) pad_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q   <= 1'b0;
      data_q <= '0;
    end else begin
      we_q <= take || pad_go;
      if (take)        data_q <= s_data_i;
      else if (pad_go) data_q <= PAD_BYTE;
    end
  end
endmodule

// File: rtl/cfg_load_seq.sv
`timescale 1ns/1ps
module cfg_load_seq
  import cfg_load_pkg::*;
#(
  parameter int                CLK_PER_TICK = 100,
  parameter int                POLL_TICKS   = 100,
  parameter int                MAX_POLLS    = 100,
  parameter int                LEN_W        = 24,
  parameter int                DATA_W       = 8,
  parameter int                ID_W         = 32,
  parameter logic [DATA_W-1:0] PAD_BYTE     = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              reset_only_i,
  input  logic              auto_i,
  input  logic              por_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [ID_W-1:0]   new_id_i,
  input  logic [ID_W-1:0]   cur_id_i,
  input  logic [DATA_W-1:0] s_data_i,
  input  logic              s_valid_i,
  output logic              s_ready_o,
  output logic              prog_no,
  input  logic              init_i,
  input  logic              done_i,
  output logic              load_mode_o,
  output logic [DATA_W-1:0] dev_data_o,
  output logic              dev_we_o,
  output logic              busy_o,
  output logic              fin_o,
  output logic [2:0]        err_o
);
  seq_state_e state_q, state_d;
  load_err_e  err_q, err_d;
  logic       rst_only_q, rst_only_d;
  logic       tick, poll, last, timer_clr, pump_ld, pump_empty;
  logic       up_to_date;

  cfg_us_tick #(.CLK_PER_TICK(CLK_PER_TICK)) tick_i (
    .clk_i, .rst_ni, .clr_i(timer_clr), .tick_o(tick)
  );

  cfg_poll_timer #(.POLL_TICKS(POLL_TICKS), .MAX_POLLS(MAX_POLLS)) poll_i (
    .clk_i, .rst_ni, .clr_i(timer_clr), .tick_i(tick), .poll_o(poll), .last_o(last)
  );

  cfg_byte_pump #(.LEN_W(LEN_W), .DATA_W(DATA_W), .PAD_BYTE(PAD_BYTE)) pump_i (
    .clk_i, .rst_ni,
    .ld_i(pump_ld), .len_i, .en_i(state_q == ST_STREAM),
    .s_data_i, .s_valid_i, .s_ready_o,
    .dev_data_o, .dev_we_o, .empty_o(pump_empty)
  );

  assign up_to_date = auto_i && !por_i && done_i && (new_id_i == cur_id_i);

  always_comb begin
    state_d    = state_q;
    err_d      = err_q;
    rst_only_d = rst_only_q;
    pump_ld    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          if (up_to_date) begin
            state_d = ST_FIN;
            err_d   = ERR_SKIPPED;
          end else begin
            state_d    = ST_PROG_LO;
            rst_only_d = 1'b0;
            pump_ld    = 1'b1;
          end
        end else if (reset_only_i) begin
          state_d    = ST_PROG_LO;
          rst_only_d = 1'b1;
        end
      end
      ST_PROG_LO: if (poll) begin
        if (!init_i) state_d = ST_PROG_HI;
        else if (last) begin
          state_d = ST_FIN;
          err_d   = ERR_RST_TIMEOUT;
        end
      end
      ST_PROG_HI: if (poll) begin
        if (init_i) begin
          if (rst_only_q) begin
            state_d = ST_FIN;
            err_d   = ERR_OK;
          end else begin
            state_d = ST_STREAM;
          end
        end else if (last) begin
          state_d = ST_FIN;
          err_d   = ERR_RST_TIMEOUT;
        end
      end
      ST_STREAM: if (pump_empty) state_d = ST_WAIT_DONE;
      ST_WAIT_DONE: if (poll) begin
        if (done_i) begin
          state_d = ST_FIN;
          err_d   = ERR_OK;
        end else if (last) begin
          state_d = ST_FIN;
          err_d   = init_i ? ERR_BAD_SIZE : ERR_BAD_CRC;
        end
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // every state entry restarts the poll interval from zero
  assign timer_clr = (state_d != state_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      err_q      <= ERR_OK;
      rst_only_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      err_q      <= err_d;
      rst_only_q <= rst_only_d;
    end
  end

  assign prog_no     = (state_q != ST_PROG_LO);
  assign load_mode_o = (state_q == ST_STREAM);
  assign busy_o      = (state_q != ST_IDLE);
  assign fin_o       = (state_q == ST_FIN);
  assign err_o       = err_q;
endmodule

// File: rtl/cfg_load_seq_chk.sv
`timescale 1ns/1ps
module cfg_load_seq_chk #(
  parameter int                ID_W     = 32,
  parameter int                DATA_W   = 8,
  parameter logic [DATA_W-1:0] PAD_BYTE = '0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              auto_i,
  input logic              por_i,
  input logic              done_i,
  input logic [ID_W-1:0]   new_id_i,
  input logic [ID_W-1:0]   cur_id_i,
  input logic              s_valid_i,
  input logic              s_ready_o,
  input logic              prog_no,
  input logic              load_mode_o,
  input logic [DATA_W-1:0] dev_data_o,
  input logic              dev_we_o,
  input logic              busy_o,
  input logic              fin_o,
  input logic [2:0]        err_o
);
  assert_ready_in_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_ready_o |-> load_mode_o);

  assert_write_in_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_we_o |-> load_mode_o);

  assert_prog_apart_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prog_no |-> (!load_mode_o && !s_ready_o));

  assert_pad_value_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_we_o && !$past(s_valid_i && s_ready_o)) |-> (dev_data_o == PAD_BYTE));

  assert_fin_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_o |=> !fin_o);

  assert_fin_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_o |-> busy_o);

  assert_skip_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && auto_i && !por_i && done_i && (new_id_i == cur_id_i))
      |=> (fin_o && err_o == 3'd4));

  assert_err_code_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_o |-> (err_o <= 3'd4));
endmodule

bind cfg_load_seq cfg_load_seq_chk #(.ID_W(ID_W), .DATA_W(DATA_W), .PAD_BYTE(PAD_BYTE)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .auto_i(auto_i), .por_i(por_i),
  .done_i(done_i), .new_id_i(new_id_i), .cur_id_i(cur_id_i), .s_valid_i(s_valid_i),
  .s_ready_o(s_ready_o), .prog_no(prog_no), .load_mode_o(load_mode_o),
  .dev_data_o(dev_data_o), .dev_we_o(dev_we_o), .busy_o(busy_o), .fin_o(fin_o),
  .err_o(err_o)
);

// File: tb/cfg_load_seq_tb_top.sv
`timescale 1ns/1ps
module cfg_load_seq_tb_top;
  localparam int CT = 2;
  localparam int PT = 3;
  localparam int MP = 4;
  localparam int LEN_W = 8;
  localparam int POLL_CYC = CT * PT;
  localparam int TO_CYC = MP * POLL_CYC;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, reset_only_i = 1'b0, auto_i = 1'b0, por_i = 1'b0;
  logic [LEN_W-1:0] len_i = '0;
  logic [31:0] new_id_i = '0, cur_id_i = '0;
  logic [7:0] s_data_i = '0;
  logic s_valid_i = 1'b0;
  logic s_ready_o, prog_no, init_i, load_mode_o, dev_we_o, busy_o, fin_o;
  logic done_i = 1'b0;
  logic [7:0] dev_data_o;
  logic [2:0] err_o;

  int checks = 0, errors = 0, cyc = 0;
  int init_mode = 0, gap = 0;
  int src_idx = 0, src_len = 0;
  int wr_cnt = 0, fin_cnt = 0, out_viol = 0, pulse_viol = 0, prog_low_cyc = 0;
  bit lm_seen = 0, prog_seen = 0, rdy_seen = 0, fin_prev = 0, wd_fired = 0;
  logic [7:0] wr_buf [32];
  logic [1:0] prog_dly = 2'b11;

  always #2 clk_i = ~clk_i;

  assign init_i = (init_mode == 1) ? 1'b1 :
                  (init_mode == 2) ? 1'b0 :
                  (init_mode == 3 && lm_seen && !load_mode_o) ? 1'b0 : prog_dly[1];

  cfg_load_seq #(.CLK_PER_TICK(CT), .POLL_TICKS(PT), .MAX_POLLS(MP), .LEN_W(LEN_W),
                 .DATA_W(8), .ID_W(32), .PAD_BYTE(8'h00)) dut_i (
    .clk_i, .rst_ni, .start_i, .reset_only_i, .auto_i, .por_i, .len_i,
    .new_id_i, .cur_id_i, .s_data_i, .s_valid_i, .s_ready_o, .prog_no,
    .init_i, .done_i, .load_mode_o, .dev_data_o, .dev_we_o, .busy_o, .fin_o, .err_o
  );

  function automatic logic [7:0] src_byte(int k, int n);
    return 8'((k * 37 + n * 5 + 1) & 255);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    cyc++;
    if (cyc > 150000 && !wd_fired) begin
      wd_fired = 1;
      chk(0, "watchdog", cyc, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    if (dev_we_o) begin
      if (wr_cnt < 32) wr_buf[wr_cnt] = dev_data_o;
      wr_cnt++;
      if (!load_mode_o) out_viol++;
    end
    if (s_ready_o && !load_mode_o) out_viol++;
    if (load_mode_o) lm_seen = 1;
    if (s_ready_o) rdy_seen = 1;
    if (!prog_no) begin
      prog_seen = 1;
      prog_low_cyc++;
    end
    if (fin_o) fin_cnt++;
    if (fin_o && fin_prev) pulse_viol++;
    fin_prev = fin_o;
    prog_dly = {prog_dly[0], prog_no};
    if (src_idx < src_len && (gap == 0 || (cyc % gap) != 0)) begin
      s_valid_i = 1'b1;
      s_data_i  = src_byte(src_idx, src_len);
    end else begin
      s_valid_i = 1'b0;
      s_data_i  = '0;
    end
    #1;
    if (s_valid_i && s_ready_o) src_idx++;
  end

  task automatic run_cmd(input bit is_load, input int len, input bit au, input bit po,
                         input logic [31:0] nid, input logic [31:0] cid, input int restart_at,
                         output int err, output int elapsed);
    @(negedge clk_i);
    wr_cnt = 0; fin_cnt = 0; out_viol = 0; pulse_viol = 0; prog_low_cyc = 0;
    lm_seen = 0; prog_seen = 0; rdy_seen = 0;
    src_idx = 0; src_len = is_load ? len : 0;
    len_i = LEN_W'(len); auto_i = au; por_i = po; new_id_i = nid; cur_id_i = cid;
    if (is_load) start_i = 1'b1; else reset_only_i = 1'b1;
    elapsed = 0;
    do begin
      @(negedge clk_i);
      start_i = 1'b0; reset_only_i = 1'b0;
      elapsed++;
      if (elapsed == restart_at) begin
        len_i = LEN_W'(len + 3);
        start_i = 1'b1;
        reset_only_i = 1'b1;
      end
    end while (!fin_o && elapsed < 3000);
    err = int'(err_o);
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    int err, el, bad, exp_n;
    repeat (3) @(negedge clk_i);
    chk(prog_no == 1'b1, "R1 prog_no in reset", int'(prog_no), 1);
    chk(!s_ready_o && !dev_we_o && !load_mode_o, "R1 port idle in reset",
        int'({s_ready_o, dev_we_o, load_mode_o}), 0);
    chk(!busy_o && !fin_o, "R1 busy/fin in reset", int'({busy_o, fin_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(prog_no && !busy_o && !s_ready_o, "R1 after reset", int'({prog_no, busy_o, s_ready_o}), 4);

    // sweep of lengths and stream gaps, healthy device
    init_mode = 0; done_i = 1'b1;
    for (int g = 0; g < 2; g++) begin
      gap = (g == 0) ? 0 : 3;
      for (int n = 0; n < 10; n++) begin
        run_cmd(1, n, 0, 0, 0, 0, -1, err, el);
        exp_n = n + (n & 1);
        chk(err == 0, "R7 load ok", err, 0);
        chk(wr_cnt == exp_n, "R6 write count", wr_cnt, exp_n);
        bad = 0;
        for (int k = 0; k < n; k++) if (wr_buf[k] != src_byte(k, n)) bad++;
        chk(bad == 0, "R5 byte order", bad, 0);
        if (n % 2 == 1) chk(wr_buf[n] == 8'h00, "R6 pad byte", int'(wr_buf[n]), 0);
        chk(out_viol == 0, "R5 ready/write only in load mode", out_viol, 0);
        chk(fin_cnt == 1 && pulse_viol == 0, "R11 single fin pulse", fin_cnt, 1);
        chk(prog_low_cyc == POLL_CYC, "R2 prog low until first poll", prog_low_cyc, POLL_CYC);
      end
    end
    gap = 0;

    // phase one stuck: init never drops
    init_mode = 1;
    run_cmd(1, 4, 0, 0, 0, 0, -1, err, el);
    chk(err == 1, "R4 phase one timeout code", err, 1);
    chk(el == TO_CYC + 1, "R4 phase one timeout latency", el, TO_CYC + 1);
    chk(!rdy_seen && wr_cnt == 0, "R4 no stream after timeout", wr_cnt, 0);

    // phase two stuck: init never rises
    init_mode = 2;
    run_cmd(1, 4, 0, 0, 0, 0, -1, err, el);
    chk(err == 1, "R3 phase two timeout code", err, 1);
    chk(el == POLL_CYC + TO_CYC + 1, "R3 phase two latency", el, POLL_CYC + TO_CYC + 1);
    chk(prog_low_cyc == POLL_CYC && !lm_seen, "R3 prog released, no load", prog_low_cyc, POLL_CYC);

    // done never rises
    init_mode = 0; done_i = 1'b0;
    run_cmd(1, 5, 0, 0, 0, 0, -1, err, el);
    chk(err == 2, "R8 invalid size with init high", err, 2);
    chk(wr_cnt == 6, "R8 bytes written before wait", wr_cnt, 6);
    init_mode = 3;
    run_cmd(1, 5, 0, 0, 0, 0, -1, err, el);
    chk(err == 3, "R8 checksum error with init low", err, 3);

    // up-to-date skip and its negations
    init_mode = 0; done_i = 1'b1;
    run_cmd(1, 6, 1, 0, 32'hA5C3_0102, 32'hA5C3_0102, -1, err, el);
    chk(err == 4, "R9 skip code", err, 4);
    chk(el == 1, "R9 skip latency", el, 1);
    chk(!prog_seen && wr_cnt == 0, "R9 device untouched", wr_cnt, 0);
    run_cmd(1, 6, 1, 1, 32'hA5C3_0102, 32'hA5C3_0102, -1, err, el);
    chk(err == 0 && wr_cnt == 6, "R9 power-on forces load", wr_cnt, 6);
    run_cmd(1, 6, 1, 0, 32'hA5C3_0102, 32'hA5C3_0103, -1, err, el);
    chk(err == 0 && wr_cnt == 6, "R9 new id forces load", wr_cnt, 6);
    run_cmd(1, 6, 0, 0, 32'h0000_0007, 32'h0000_0007, -1, err, el);
    chk(err == 0 && wr_cnt == 6, "R9 manual load never skips", wr_cnt, 6);
    done_i = 1'b0;
    run_cmd(1, 2, 1, 0, 32'h11, 32'h11, -1, err, el);
    chk(err == 2 && prog_seen, "R9 done low forces load", err, 2);

    // reset-only command
    done_i = 1'b1; init_mode = 0;
    run_cmd(0, 0, 0, 0, 0, 0, -1, err, el);
    chk(err == 0, "R10 reset-only ok", err, 0);
    chk(prog_seen && !lm_seen && wr_cnt == 0, "R10 no load mode", int'(lm_seen), 0);
    init_mode = 1;
    run_cmd(0, 0, 0, 0, 0, 0, -1, err, el);
    chk(err == 1, "R10 reset-only timeout", err, 1);

    // commands while busy are ignored
    init_mode = 0;
    run_cmd(1, 4, 0, 0, 0, 0, 3, err, el);
    chk(err == 0 && wr_cnt == 4, "R11 restart ignored, count", wr_cnt, 4);
    chk(fin_cnt == 1, "R11 one fin for one command", fin_cnt, 1);
    run_cmd(1, 3, 0, 0, 0, 0, -1, err, el);
    chk(err == 0 && wr_cnt == 4, "R11 next command accepted", wr_cnt, 4);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule